// File: doc/BRIEF.md
# Serial Flash Parameter Discovery Engine

This block runs once after reset and learns the geometry of an attached serial NOR flash from the flash's self-description area. It drives a byte-oriented command port of an SPI master. First it reads the descriptor header and checks its signature. It then walks every parameter header and keeps the newest compatible basic parameter table. From that table it reads the program page size and the capacity in bytes.

Once discovery ends, whether it succeeded or failed, the engine issues a write-enable. It then issues a command that puts the flash into 3-byte or 4-byte addressing, chosen from the capacity it holds. The results are held on the outputs until the next reset. A failure is reported as an error code, and the preset capacity and page size then stay in force.

Top module: `sfdp_discovery`

## Requirements
- R1: Every descriptor read uses opcode 0x5A with `cmd_addr_en` high and a 24-bit byte address of table base + (dword number − 1) × 4. Dword numbers start at 1. The master returns four bytes, and the first byte received becomes bits 7:0 of the assembled word.
- R2: The engine first reads dwords 1 and 2 at base 0. If dword 1 is not 0x50444653, `err_code` becomes 1 and no parameter header is read.
- R3: The number of parameter headers is header dword 2 bits 23:16 plus one. Header i (counting from 0) has its two dwords read at base 8 + 8·i, in header order.
- R4: A header names the basic table only when the descriptor major revision (header dword 2 bits 15:8) is 1 and its ID low byte (its dword 1 bits 7:0) is 0x00. When the descriptor minor revision (header dword 2 bits 7:0) is 5 or more, its ID high byte (its dword 2 bits 31:24) must also be 0xFF.
- R5: A basic-table header is accepted when its table major revision (dword 1 bits 23:16) is 1 and its table minor revision (bits 15:8) is at least that of the best accepted so far. On equal minor revisions the later header wins. If no header is accepted, `err_code` becomes 2.
- R6: The accepted table's base is its header dword 2 bits 23:0. `tbl_bytes` gives its length field (dword 1 bits 31:24) multiplied by 4.
- R7: If the table minor revision is below 5, the page size is 64 when bit 2 of table dword 1 is set and 1 otherwise. At minor revision 5 or more, the page size is 2 raised to bits 7:4 of table dword 11.
- R8: If bit 31 of table dword 2 is clear, the capacity is (bits 30:0 >> 3) + 1.
- R9: If bit 31 of table dword 2 is set, the capacity is 2^(N−3), where N is bits 30:0. If N is below 3, or the result would reach 4 GiB, `err_code` becomes 3.
- R10: After any error, `capacity` and `page_size` keep the preset values `DEF_CAPACITY` and `DEF_PAGE`. These are also the values shown during reset.
- R11: After discovery, the engine sends opcode 0x06 with no address. It then sends 0xB7 if the capacity is greater than 0x1000000, and 0xE9 otherwise. `addr4b` reports the mode chosen once that command is done.
- R12: Only one command is outstanding at a time. `done` stays low until the mode command completes, then stays high with stable results, and no further command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; discovery starts on release |
| cmd_start | output | 1 | One-cycle pulse launching a command on the SPI master |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 24 | Byte address, sent most significant byte first, then one dummy byte |
| cmd_addr_en | output | 1 | High when the command carries address and dummy byte |
| cmd_rx_len | output | 3 | Number of bytes to receive (4 or 0) |
| cmd_rx_valid | input | 1 | Received byte strobe |
| cmd_rx_byte | input | 8 | Received byte |
| cmd_done | input | 1 | Command finished pulse |
| capacity | output | 32 | Capacity in bytes |
| page_size | output | 16 | Program page size in bytes |
| tbl_bytes | output | 10 | Length of the accepted basic table in bytes |
| addr4b | output | 1 | Flash placed in 4-byte addressing |
| done | output | 1 | Discovery and mode setting complete |
| err_code | output | 2 | 0 ok, 1 bad signature, 2 no table, 3 capacity overflow |

## Verification
The case that is hardest to reach from the ports is a walk over several headers that mixes a rejected ID high byte, a lower-revision table and a tie on revision. In that walk, a wrong choice of header still yields a plausible geometry. The bench models the flash as a byte image and places decoy tables at the pointers of the rejected headers. It gives each decoy a distinct page-size field and capacity field, so choosing a decoy shows up both in the address of the next read and in the final outputs. Capacity corners are covered by separate images: exactly 16 MiB (3-byte mode kept), an exponent reaching 4 GiB (overflow with defaults kept), and a bad signature.

// File: rtl/sfdp_disc_pkg.sv
package sfdp_disc_pkg;

  localparam int ADDR_W   = 24;
  localparam int CAP_W    = 32;
  localparam int PG_W     = 16;
  localparam int DW_BYTES = 4;
  localparam int LEN_W    = $clog2(DW_BYTES + 1);
  localparam int TLEN_W   = 10;

  localparam logic [7:0] OP_RD_SFDP   = 8'h5A;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_ADDR4_ON  = 8'hB7;
  localparam logic [7:0] OP_ADDR4_OFF = 8'hE9;

  localparam logic [31:0]      SFDP_MAGIC   = 32'h5044_4653;
  localparam logic [CAP_W-1:0] CAP_4B_LIMIT = 32'h0100_0000;
  localparam logic [7:0]       NEW_ID_MINOR = 8'd5;

  typedef enum logic [1:0] {
    DISC_OK       = 2'd0,
    DISC_BAD_SIG  = 2'd1,
    DISC_NO_TABLE = 2'd2,
    DISC_CAP_OVF  = 2'd3
  } disc_err_e;

  typedef enum logic [3:0] {
    S_SIG1, S_SIG2, S_PH1, S_PH2, S_PICK,
    S_PG, S_CAP, S_COMMIT, S_WREN, S_MODE, S_END
  } disc_state_e;

  typedef struct packed {
    logic             ovf;
    logic [CAP_W-1:0] bytes;
  } cap_res_t;

  // Byte address of a 1-based dword inside a table.
  function automatic logic [ADDR_W-1:0] f_dw_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [3:0] dw_num);
    logic [3:0] idx;
    idx = dw_num - 4'd1;
    return base + {{(ADDR_W-6){1'b0}}, idx, 2'b00};
  endfunction

  // Which table dword carries the page size information.
  function automatic logic [3:0] f_page_dw(input logic [7:0] tbl_minor);
    return (tbl_minor < NEW_ID_MINOR) ? 4'd1 : 4'd11;
  endfunction

  function automatic logic [PG_W-1:0] f_page_bytes(input logic [7:0]  tbl_minor,
                                                  input logic [31:0] dw);
    logic [PG_W-1:0] pg;
    if (tbl_minor < NEW_ID_MINOR) pg = dw[2] ? PG_W'(64) : PG_W'(1);
    else                          pg = PG_W'(1) << dw[7:4];
    return pg;
  endfunction

  function automatic cap_res_t f_cap_decode(input logic [31:0] dw);
    cap_res_t   r;
    logic [30:0] n;
    n = dw[30:0];
    r.ovf   = 1'b0;
    r.bytes = '0;
    if (dw[31]) begin
      if ((n < 31'd3) || (n > 31'd34)) r.ovf = 1'b1;
      else                             r.bytes = CAP_W'(1) << (n - 31'd3);
    end else begin
      r.bytes = {4'd0, n[30:3]} + CAP_W'(1);
    end
    return r;
  endfunction

endpackage

// File: rtl/sfdp_word_fetch.sv
module sfdp_word_fetch
  import sfdp_disc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [7:0]          go_op,
  input  logic [ADDR_W-1:0]   go_addr,
  input  logic                go_addr_en,
  output logic                cmd_start,
  output logic [7:0]          cmd_opcode,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic                cmd_addr_en,
  output logic [LEN_W-1:0]    cmd_rx_len,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  input  logic                cmd_done,
  output logic                busy,
  output logic                fin,
  output logic [8*DW_BYTES-1:0] word
);

  localparam int IDX_W = $clog2(DW_BYTES);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_start   <= 1'b0;
      cmd_opcode  <= '0;
      cmd_addr    <= '0;
      cmd_addr_en <= 1'b0;
      cmd_rx_len  <= '0;
      busy        <= 1'b0;
      fin         <= 1'b0;
      idx_q       <= '0;
    end else begin
      cmd_start <= go;
      fin       <= busy && cmd_done;
      if (go) begin
        cmd_opcode  <= go_op;
        cmd_addr    <= go_addr;
        cmd_addr_en <= go_addr_en;
        cmd_rx_len  <= go_addr_en ? LEN_W'(DW_BYTES) : '0;
        busy        <= 1'b1;
        idx_q       <= '0;
      end else if (busy) begin
        if (rx_valid) idx_q <= idx_q + 1'b1;
        if (cmd_done) busy <= 1'b0;
      end
    end
  end

  // One register per received byte lane; first byte lands in the low lane.
  for (genvar g = 0; g < DW_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n || go) lane_q <= '0;
      else if (busy && rx_valid && (idx_q == IDX_W'(g))) lane_q <= rx_byte;
    end
    assign word[8*g +: 8] = lane_q;
  end

endmodule

// File: rtl/sfdp_table_pick.sv
module sfdp_table_pick
  import sfdp_disc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [7:0]        sfdp_major,
  input  logic [7:0]        sfdp_minor,
  input  logic [31:0]       ph_lo,
  input  logic [31:0]       ph_hi,
  output logic              hit,
  output logic              found,
  output logic [7:0]        best_minor,
  output logic [ADDR_W-1:0] tbl_ptr,
  output logic [TLEN_W-1:0] tbl_bytes
);

  logic id_low_ok, id_high_ok, id_ok, rev_ok;

  assign id_low_ok  = (ph_lo[7:0] == 8'h00);
  assign id_high_ok = (sfdp_minor < NEW_ID_MINOR) || (ph_hi[31:24] == 8'hFF);
  assign id_ok      = (sfdp_major == 8'd1) && id_low_ok && id_high_ok;
  assign rev_ok     = (ph_lo[23:16] == 8'd1) && (ph_lo[15:8] >= best_minor);
  assign hit        = eval && id_ok && rev_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found      <= 1'b0;
      best_minor <= '0;
      tbl_ptr    <= '0;
      tbl_bytes  <= '0;
    end else if (hit) begin
      found      <= 1'b1;
      best_minor <= ph_lo[15:8];
      tbl_ptr    <= ph_hi[ADDR_W-1:0];
      tbl_bytes  <= {ph_lo[31:24], 2'b00};
    end
  end

endmodule

// File: rtl/sfdp_geom_decode.sv
module sfdp_geom_decode
  import sfdp_disc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_load,
  input  logic             cap_load,
  input  logic [7:0]       tbl_minor,
  input  logic [31:0]      word,
  output logic [PG_W-1:0]  pg_bytes,
  output logic [CAP_W-1:0] cap_bytes,
  output logic             cap_ovf
);

  cap_res_t cap_res;
  assign cap_res = f_cap_decode(word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_bytes  <= '0;
      cap_bytes <= '0;
      cap_ovf   <= 1'b0;
    end else begin
      if (pg_load) pg_bytes <= f_page_bytes(tbl_minor, word);
      if (cap_load) begin
        cap_bytes <= cap_res.bytes;
        cap_ovf   <= cap_res.ovf;
      end
    end
  end

endmodule

// File: rtl/sfdp_discovery.sv
module sfdp_discovery
  import sfdp_disc_pkg::*;
#(
  parameter logic [31:0] DEF_CAPACITY = 32'h0010_0000,
  parameter logic [15:0] DEF_PAGE     = 16'd256
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        cmd_start,
  output logic [7:0]  cmd_opcode,
  output logic [23:0] cmd_addr,
  output logic        cmd_addr_en,
  output logic [2:0]  cmd_rx_len,
  input  logic        cmd_rx_valid,
  input  logic [7:0]  cmd_rx_byte,
  input  logic        cmd_done,
  output logic [31:0] capacity,
  output logic [15:0] page_size,
  output logic [9:0]  tbl_bytes,
  output logic        addr4b,
  output logic        done,
  output logic [1:0]  err_code
);

  disc_state_e        st;
  logic               launched;
  logic [31:0]        sig_q;
  logic [7:0]         sfdp_min, sfdp_maj;
  logic [8:0]         ph_left;
  logic [ADDR_W-1:0]  ph_off;
  logic [31:0]        ph_lo_q;
  disc_err_e          err_q;
  logic [CAP_W-1:0]   cap_q;
  logic [PG_W-1:0]    page_q;
  logic               a4_q, done_q;

  // Named internal events
  logic               is_cmd, go, rd_busy, fin;
  logic [7:0]         c_op;
  logic [ADDR_W-1:0]  c_addr;
  logic               c_aen;
  logic [31:0]        word;
  logic               ph_eval, pg_load, cap_load;
  logic               sel_hit, sel_found;
  logic [7:0]         best_minor;
  logic [ADDR_W-1:0]  tbl_ptr;
  logic [PG_W-1:0]    dec_pg;
  logic [CAP_W-1:0]   dec_cap;
  logic               dec_ovf;
  logic               want_4b;

  assign want_4b = (cap_q > CAP_4B_LIMIT);

  always_comb begin
    is_cmd = 1'b1;
    c_op   = OP_RD_SFDP;
    c_aen  = 1'b1;
    c_addr = '0;
    case (st)
      S_SIG1: c_addr = f_dw_addr('0, 4'd1);
      S_SIG2: c_addr = f_dw_addr('0, 4'd2);
      S_PH1:  c_addr = f_dw_addr(ph_off, 4'd1);
      S_PH2:  c_addr = f_dw_addr(ph_off, 4'd2);
      S_PG:   c_addr = f_dw_addr(tbl_ptr, f_page_dw(best_minor));
      S_CAP:  c_addr = f_dw_addr(tbl_ptr, 4'd2);
      S_WREN: begin
        c_op  = OP_WR_EN;
        c_aen = 1'b0;
      end
      S_MODE: begin
        c_op  = want_4b ? OP_ADDR4_ON : OP_ADDR4_OFF;
        c_aen = 1'b0;
      end
      default: is_cmd = 1'b0;
    endcase
  end

  assign go       = is_cmd && !launched && !rd_busy;
  assign ph_eval  = (st == S_PH2) && fin;
  assign pg_load  = (st == S_PG)  && fin;
  assign cap_load = (st == S_CAP) && fin;

  sfdp_word_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_op      (c_op),
    .go_addr    (c_addr),
    .go_addr_en (c_aen),
    .cmd_start  (cmd_start),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr),
    .cmd_addr_en(cmd_addr_en),
    .cmd_rx_len (cmd_rx_len),
    .rx_valid   (cmd_rx_valid),
    .rx_byte    (cmd_rx_byte),
    .cmd_done   (cmd_done),
    .busy       (rd_busy),
    .fin        (fin),
    .word       (word)
  );

  sfdp_table_pick u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (ph_eval),
    .sfdp_major(sfdp_maj),
    .sfdp_minor(sfdp_min),
    .ph_lo     (ph_lo_q),
    .ph_hi     (word),
    .hit       (sel_hit),
    .found     (sel_found),
    .best_minor(best_minor),
    .tbl_ptr   (tbl_ptr),
    .tbl_bytes (tbl_bytes)
  );

  sfdp_geom_decode u_geom (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_load  (pg_load),
    .cap_load (cap_load),
    .tbl_minor(best_minor),
    .word     (word),
    .pg_bytes (dec_pg),
    .cap_bytes(dec_cap),
    .cap_ovf  (dec_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_SIG1;
      launched <= 1'b0;
      sig_q    <= '0;
      sfdp_min <= '0;
      sfdp_maj <= '0;
      ph_left  <= '0;
      ph_off   <= '0;
      ph_lo_q  <= '0;
      err_q    <= DISC_OK;
      cap_q    <= DEF_CAPACITY;
      page_q   <= DEF_PAGE;
      a4_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (go)       launched <= 1'b1;
      else if (fin) launched <= 1'b0;
      case (st)
        S_SIG1: if (fin) begin
          sig_q <= word;
          st    <= S_SIG2;
        end
        S_SIG2: if (fin) begin
          if (sig_q != SFDP_MAGIC) begin
            err_q <= DISC_BAD_SIG;
            st    <= S_WREN;
          end else begin
            sfdp_min <= word[7:0];
            sfdp_maj <= word[15:8];
            ph_left  <= {1'b0, word[23:16]} + 9'd1;
            ph_off   <= ADDR_W'(8);
            st       <= S_PH1;
          end
        end
        S_PH1: if (fin) begin
          ph_lo_q <= word;
          st      <= S_PH2;
        end
        S_PH2: if (fin) begin
          ph_left <= ph_left - 9'd1;
          ph_off  <= ph_off + ADDR_W'(8);
          st      <= (ph_left == 9'd1) ? S_PICK : S_PH1;
        end
        S_PICK: begin
          if (sel_found) st <= S_PG;
          else begin
            err_q <= DISC_NO_TABLE;
            st    <= S_WREN;
          end
        end
        S_PG:  if (fin) st <= S_CAP;
        S_CAP: if (fin) st <= S_COMMIT;
        S_COMMIT: begin
          if (dec_ovf) err_q <= DISC_CAP_OVF;
          else begin
            cap_q  <= dec_cap;
            page_q <= dec_pg;
          end
          st <= S_WREN;
        end
        S_WREN: if (fin) st <= S_MODE;
        S_MODE: if (fin) begin
          a4_q   <= want_4b;
          done_q <= 1'b1;
          st     <= S_END;
        end
        default: ;
      endcase
    end
  end

  assign capacity  = cap_q;
  assign page_size = page_q;
  assign addr4b    = a4_q;
  assign done      = done_q;
  assign err_code  = err_q;

endmodule

// File: rtl/sfdp_discovery_chk.sv
module sfdp_discovery_chk #(
  parameter logic [31:0] P_DEF_CAP  = 32'h0010_0000,
  parameter logic [15:0] P_DEF_PAGE = 16'd256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic [7:0]  cmd_opcode,
  input logic [23:0] cmd_addr,
  input logic        cmd_addr_en,
  input logic        cmd_done,
  input logic [31:0] capacity,
  input logic [15:0] page_size,
  input logic        addr4b,
  input logic        done,
  input logic [1:0]  err_code,
  input logic        sel_hit,
  input logic        sel_found
);

  logic       outstanding;
  logic [7:0] last_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      last_op     <= 8'h00;
    end else begin
      if (cmd_start)     outstanding <= 1'b1;
      else if (cmd_done) outstanding <= 1'b0;
      if (cmd_start) last_op <= cmd_opcode;
    end
  end

  a_r1_read_form: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && cmd_addr_en |-> cmd_opcode == 8'h5A && cmd_addr[1:0] == 2'b00);

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !outstanding);

  a_r11_wren_before_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && (cmd_opcode == 8'hB7 || cmd_opcode == 8'hE9) |-> last_op == 8'h06);

  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(capacity) && $stable(page_size) && $stable(addr4b));

  a_r12_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_start);

  a_r11_mode_matches_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> addr4b == (capacity > 32'h0100_0000));

  a_r10_defaults_kept: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code != 2'd0 |-> capacity == P_DEF_CAP && page_size == P_DEF_PAGE);

  a_r7_page_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(page_size) == 1);

  a_r5_hit_records: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> sel_found);

endmodule

bind sfdp_discovery sfdp_discovery_chk #(
  .P_DEF_CAP (DEF_CAPACITY),
  .P_DEF_PAGE(DEF_PAGE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .cmd_opcode (cmd_opcode),
  .cmd_addr   (cmd_addr),
  .cmd_addr_en(cmd_addr_en),
  .cmd_done   (cmd_done),
  .capacity   (capacity),
  .page_size  (page_size),
  .addr4b     (addr4b),
  .done       (done),
  .err_code   (err_code),
  .sel_hit    (sel_hit),
  .sel_found  (sel_found)
);

// File: tb/sim_sfdp_discovery.sv
`timescale 1ns/1ps
module sim_sfdp_discovery;

  localparam logic [31:0] DEF_CAP  = 32'h0010_0000;
  localparam logic [15:0] DEF_PG   = 16'd256;
  localparam int          MEM_SZ   = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start, cmd_addr_en, addr4b, done;
  logic [7:0]  cmd_opcode;
  logic [23:0] cmd_addr;
  logic [2:0]  cmd_rx_len;
  logic        cmd_rx_valid = 1'b0;
  logic [7:0]  cmd_rx_byte = 8'h00;
  logic        cmd_done = 1'b0;
  logic [31:0] capacity;
  logic [15:0] page_size;
  logic [9:0]  tbl_bytes;
  logic [1:0]  err_code;

  always #4 clk = ~clk;

  sfdp_discovery #(.DEF_CAPACITY(DEF_CAP), .DEF_PAGE(DEF_PG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_addr_en(cmd_addr_en), .cmd_rx_len(cmd_rx_len),
    .cmd_rx_valid(cmd_rx_valid), .cmd_rx_byte(cmd_rx_byte), .cmd_done(cmd_done),
    .capacity(capacity), .page_size(page_size), .tbl_bytes(tbl_bytes),
    .addr4b(addr4b), .done(done), .err_code(err_code)
  );

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0] mem [MEM_SZ];

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic        aen;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'h00;
    exp_q.delete();
  endtask

  task automatic put_dw(input int a, input logic [31:0] v);
    mem[a]   = v[7:0];
    mem[a+1] = v[15:8];
    mem[a+2] = v[23:16];
    mem[a+3] = v[31:24];
  endtask

  task automatic exp_rd(input logic [23:0] a);
    exp_q.push_back('{op: 8'h5A, addr: a, aen: 1'b1});
  endtask

  task automatic exp_ctl(input logic [7:0] op);
    exp_q.push_back('{op: op, addr: 24'h0, aen: 1'b0});
  endtask

  // Monitor and SPI master model: pops the expected command, then serves bytes.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_start) begin
        logic [7:0]  op;
        logic [23:0] a;
        logic        aen;
        int          len;
        op = cmd_opcode; a = cmd_addr; aen = cmd_addr_en; len = int'(cmd_rx_len);
        if (exp_q.size() == 0) begin
          chk("R12 unexpected extra command", {56'h0, op}, 64'hFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.aen) begin
            chk("R1 read opcode", {56'h0, op}, {56'h0, e.op});
            chk("R1 R3 read address", {40'h0, a}, {40'h0, e.addr});
            chk("R1 receive length", 64'(len), 64'd4);
          end else begin
            chk("R11 control opcode", {56'h0, op}, {56'h0, e.op});
            chk("R11 receive length", 64'(len), 64'd0);
          end
          chk("R1 R11 address enable", {63'h0, aen}, {63'h0, e.aen});
        end
        repeat (2) @(negedge clk);
        for (int i = 0; i < len; i++) begin
          cmd_rx_valid = 1'b1;
          cmd_rx_byte  = mem[(int'(a) + i) % MEM_SZ];
          @(negedge clk);
        end
        cmd_rx_valid = 1'b0;
        cmd_done     = 1'b1;
        @(negedge clk);
        cmd_done     = 1'b0;
      end
    end
  end

  task automatic run_case(input logic [1:0] e_err, input logic [31:0] e_cap,
                          input logic [15:0] e_pg, input logic e_a4);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset done low", {63'h0, done}, 64'h0);
    chk("R10 reset capacity", {32'h0, capacity}, {32'h0, DEF_CAP});
    chk("R10 reset page", {48'h0, page_size}, {48'h0, DEF_PG});
    chk("R11 reset addr4b", {63'h0, addr4b}, 64'h0);
    rst_n = 1'b1;
    begin
      int n;
      n = 0;
      while (!done && n < 5000) begin
        @(negedge clk);
        n++;
      end
    end
    chk("R12 done reached", {63'h0, done}, 64'h1);
    chk("R2 R5 R9 error code", {62'h0, err_code}, {62'h0, e_err});
    chk("R8 R9 R10 capacity", {32'h0, capacity}, {32'h0, e_cap});
    chk("R7 R10 page size", {48'h0, page_size}, {48'h0, e_pg});
    chk("R11 addressing mode", {63'h0, addr4b}, {63'h0, e_a4});
    repeat (12) @(negedge clk);
    chk("R12 done held", {63'h0, done}, 64'h1);
    chk("R12 all commands seen", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    // Case A: rev 1.0, one header, 1.0 table, granularity set, plain capacity
    clear_mem();
    put_dw(0, 32'h5044_4653); put_dw(4, 32'hFF00_0100);
    put_dw(8, 32'h0901_0000); put_dw(12, 32'hFF00_0080);
    put_dw(128, 32'h0000_0004); put_dw(132, 32'h00FF_FFFF);
    exp_rd(24'h0); exp_rd(24'h4); exp_rd(24'h8); exp_rd(24'hC);
    exp_rd(24'h80); exp_rd(24'h84); exp_ctl(8'h06); exp_ctl(8'hE9);
    run_case(2'd0, 32'h0020_0000, 16'd64, 1'b0);
    chk("R6 table length bytes", {54'h0, tbl_bytes}, 64'd36);

    // Case B: rev 1.6, three headers, high-ID reject and lower-minor skip, 4-byte mode
    clear_mem();
    put_dw(0, 32'h5044_4653); put_dw(4, 32'hFF02_0106);
    put_dw(8,  32'h1001_0500); put_dw(12, 32'hFF00_0080);
    put_dw(16, 32'h1001_0900); put_dw(20, 32'h8100_00C0);
    put_dw(24, 32'h1001_0000); put_dw(28, 32'hFF00_0100);
    put_dw(128 + 40, 32'h0000_0090); put_dw(132, 32'h8000_001C);
    put_dw(192 + 40, 32'h0000_0030); put_dw(196, 32'h0000_7FFF);
    put_dw(256, 32'h0000_0004); put_dw(260, 32'h0000_0FFF);
    exp_rd(24'h0); exp_rd(24'h4); exp_rd(24'h8); exp_rd(24'hC);
    exp_rd(24'h10); exp_rd(24'h14); exp_rd(24'h18); exp_rd(24'h1C);
    exp_rd(24'hA8); exp_rd(24'h84); exp_ctl(8'h06); exp_ctl(8'hB7);
    run_case(2'd0, 32'h0200_0000, 16'd512, 1'b1);
    chk("R4 R6 chosen table length", {54'h0, tbl_bytes}, 64'd64);

    // Case C: bad signature
    clear_mem();
    put_dw(0, 32'h5044_4654); put_dw(4, 32'hFF00_0100);
    put_dw(8, 32'h0901_0000); put_dw(12, 32'hFF00_0080);
    exp_rd(24'h0); exp_rd(24'h4); exp_ctl(8'h06); exp_ctl(8'hE9);
    run_case(2'd1, DEF_CAP, DEF_PG, 1'b0);

    // Case D: exponent capacity reaching 4 GiB
    clear_mem();
    put_dw(0, 32'h5044_4653); put_dw(4, 32'hFF00_0100);
    put_dw(8, 32'h0901_0000); put_dw(12, 32'hFF00_0080);
    put_dw(128, 32'h0000_0004); put_dw(132, 32'h8000_0023);
    exp_rd(24'h0); exp_rd(24'h4); exp_rd(24'h8); exp_rd(24'hC);
    exp_rd(24'h80); exp_rd(24'h84); exp_ctl(8'h06); exp_ctl(8'hE9);
    run_case(2'd3, DEF_CAP, DEF_PG, 1'b0);

    // Case E: descriptor major revision 2, so no basic table qualifies
    clear_mem();
    put_dw(0, 32'h5044_4653); put_dw(4, 32'hFF00_0200);
    put_dw(8, 32'h0901_0000); put_dw(12, 32'hFF00_0080);
    exp_rd(24'h0); exp_rd(24'h4); exp_rd(24'h8); exp_rd(24'hC);
    exp_ctl(8'h06); exp_ctl(8'hE9);
    run_case(2'd2, DEF_CAP, DEF_PG, 1'b0);

    // Case F: equal minor revisions, later header wins; exactly 16 MiB stays 3-byte
    clear_mem();
    put_dw(0, 32'h5044_4653); put_dw(4, 32'hFF01_0100);
    put_dw(8,  32'h0901_0000); put_dw(12, 32'hFF00_0080);
    put_dw(16, 32'h0501_0000); put_dw(20, 32'hFF00_00C0);
    put_dw(128, 32'h0000_0004); put_dw(132, 32'h00FF_FFFF);
    put_dw(192, 32'h0000_0000); put_dw(196, 32'h8000_001B);
    exp_rd(24'h0); exp_rd(24'h4); exp_rd(24'h8); exp_rd(24'hC);
    exp_rd(24'h10); exp_rd(24'h14); exp_rd(24'hC0); exp_rd(24'hC4);
    exp_ctl(8'h06); exp_ctl(8'hE9);
    run_case(2'd0, 32'h0100_0000, 16'd1, 1'b0);
    chk("R5 R6 later header length", {54'h0, tbl_bytes}, 64'd20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog R12 run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule